// File: doc/BRIEF.md
# Precise Exception Controller for a Five-Stage Pipeline

This block decides, every cycle, whether the in-order pipeline must take an exception, and which one. Three stages may raise a request: decode reports an unknown opcode, execute reports a signed arithmetic overflow, and the memory stage may report an access fault. The memory-stage source can be removed with a parameter. A request only counts when the stage holds a live instruction. When several requests arrive in the same cycle, the oldest instruction wins. Its slot and every younger slot are turned into bubbles, and fetch is sent to a fixed handler entry.

Instructions older than the winner are left alone, so they retire normally. The flushed slot of the winner includes its register write. The unit latches the winner's PC plus four and a cause code into two registers. These stay unchanged until the next exception is taken. A plain read port shows them to the rest of the core. Flush and redirect are combinational outputs in the faulting cycle. The pipeline applies both on the same clock edge, so exactly one handler fetch follows. No data stream crosses this block, so all pins are plain control and status signals with no valid/ready handshake.

Top module: `pex_unit`

## Requirements
- R1: After reset, `epc` reads 0 and `cause` reads 0. With no live request, all flush outputs and `redirect` are low.
- R2: A live unknown-opcode request in decode, with no older request, raises `redirect`, `flush_if` and `flush_id` only. The cause code recorded is 0.
- R3: A live overflow in execute, with no older request, raises `redirect`, `flush_if`, `flush_id` and `flush_ex`. Execute's register write is therefore squashed, and `flush_mem` stays low. The cause code recorded is 1.
- R4: A live memory fault raises `redirect` and all four flush outputs. The cause code recorded is 2.
- R5: When several live requests occur in one cycle, the oldest stage wins. Memory beats execute, and execute beats decode. Flush and cause follow the winner.
- R6: On the clock edge that ends a faulting cycle, `epc` becomes the winner's PC plus 4, wrapping modulo 2^32.
- R7: In any cycle without `redirect`, `epc` and `cause` keep their values across the clock edge.
- R8: A request from a stage whose valid bit is low (a bubble or an already squashed slot) is ignored. It causes no flush and no redirect, and it does not alter `epc` or `cause`.
- R9: Whenever `redirect` is high, `redirect_pc` equals 0x80000180. `redirect` is high only during the faulting cycle itself.
- R10: With the memory-fault source disabled by parameter, a memory fault is ignored and execute becomes the oldest source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_valid | input | 1 | Decode slot holds a live instruction |
| id_pc | input | 32 | PC of the decode instruction |
| id_undef | input | 1 | Decode found an unknown opcode |
| ex_valid | input | 1 | Execute slot holds a live instruction |
| ex_pc | input | 32 | PC of the execute instruction |
| ex_ovf | input | 1 | Execute detected arithmetic overflow |
| mem_valid | input | 1 | Memory slot holds a live instruction |
| mem_pc | input | 32 | PC of the memory instruction |
| mem_fault | input | 1 | Memory stage access fault |
| flush_if | output | 1 | Squash the fetch slot |
| flush_id | output | 1 | Squash the decode slot |
| flush_ex | output | 1 | Squash the execute slot and its register write |
| flush_mem | output | 1 | Squash the memory slot |
| redirect | output | 1 | Load the handler address into the fetch PC |
| redirect_pc | output | 32 | Handler entry address |
| epc | output | 32 | Saved exception PC (PC plus 4) |
| cause | output | 2 | Saved cause: 0 opcode, 1 overflow, 2 memory fault |

## Verification
A bad priority choice shows in the same cycle as the fault: the flush pattern is wrong, or an older stage's flush is set. One clock edge later it also shows as a wrong `epc` or `cause`. A register that is written when it should not be shows on the next edge as a changed `epc` after an idle or bubble-only cycle. The failure stays visible until the next exception is taken. The bench therefore checks the combinational outputs just before each edge and the saved registers just after it.

// File: rtl/pex_pkg.sv
package pex_pkg;
  localparam int NUM_SRC = 3;
  localparam int IDX_W   = 2;

  typedef enum logic [1:0] {
    CAUSE_UNDEF = 2'd0,
    CAUSE_OVF   = 2'd1,
    CAUSE_MEMF  = 2'd2
  } cause_e;
endpackage

// File: rtl/pex_arbiter.sv
module pex_arbiter #(
  parameter int N     = 3,
  parameter int XLEN  = 32,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]      req,
  input  logic [XLEN-1:0]   pc_in [N],
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic [XLEN-1:0]   pc_sel
);
  // index 0 is the youngest source, N-1 the oldest
  always_comb begin
    hit    = 1'b0;
    idx    = '0;
    pc_sel = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) begin
        hit    = 1'b1;
        idx    = IDX_W'(i);
        pc_sel = pc_in[i];
      end
    end
  end
endmodule

// File: rtl/pex_flush_gen.sv
module pex_flush_gen #(
  parameter int N     = 3,
  parameter int IDX_W = 2
) (
  input  logic             hit,
  input  logic [IDX_W-1:0] idx,
  output logic [N:0]       flush
);
  // bit 0 is fetch; bit j is source j-1
  assign flush[0] = hit;
  for (genvar j = 1; j <= N; j++) begin : g_fl
    assign flush[j] = hit && (int'(idx) >= j - 1);
  end
endmodule

// File: rtl/pex_csr.sv
module pex_csr #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [XLEN-1:0] epc_d,
  input  logic [1:0]      cause_d,
  output logic [XLEN-1:0] epc_q,
  output logic [1:0]      cause_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= '0;
    end else if (we) begin
      epc_q   <= epc_d;
      cause_q <= cause_d;
    end
  end
endmodule

// File: rtl/pex_unit.sv
module pex_unit
  import pex_pkg::*;
#(
  parameter int          XLEN          = 32,
  parameter logic [31:0] HANDLER       = 32'h8000_0180,
  parameter bit          HAS_MEM_FAULT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            id_valid,
  input  logic [XLEN-1:0] id_pc,
  input  logic            id_undef,
  input  logic            ex_valid,
  input  logic [XLEN-1:0] ex_pc,
  input  logic            ex_ovf,
  input  logic            mem_valid,
  input  logic [XLEN-1:0] mem_pc,
  input  logic            mem_fault,
  output logic            flush_if,
  output logic            flush_id,
  output logic            flush_ex,
  output logic            flush_mem,
  output logic            redirect,
  output logic [XLEN-1:0] redirect_pc,
  output logic [XLEN-1:0] epc,
  output logic [1:0]      cause
);
  localparam int INSN_BYTES = 4;

  logic [NUM_SRC-1:0] req;
  logic [XLEN-1:0]    pcs [NUM_SRC];
  logic               hit;
  logic [IDX_W-1:0]   idx;
  logic [XLEN-1:0]    pc_sel;
  logic [NUM_SRC:0]   flush;
  cause_e             cause_d;

  assign req[0] = id_valid & id_undef;
  assign req[1] = ex_valid & ex_ovf;
  if (HAS_MEM_FAULT) begin : g_memf
    assign req[2] = mem_valid & mem_fault;
  end else begin : g_nomemf
    assign req[2] = 1'b0;
  end

  assign pcs[0] = id_pc;
  assign pcs[1] = ex_pc;
  assign pcs[2] = mem_pc;

  pex_arbiter #(.N(NUM_SRC), .XLEN(XLEN), .IDX_W(IDX_W)) u_arb (
    .req(req), .pc_in(pcs), .hit(hit), .idx(idx), .pc_sel(pc_sel)
  );

  pex_flush_gen #(.N(NUM_SRC), .IDX_W(IDX_W)) u_flush (
    .hit(hit), .idx(idx), .flush(flush)
  );

  // source index doubles as cause code
  assign cause_d = cause_e'(idx);

  pex_csr #(.XLEN(XLEN)) u_csr (
    .clk(clk), .rst_n(rst_n), .we(hit),
    .epc_d(pc_sel + XLEN'(INSN_BYTES)), .cause_d(cause_d),
    .epc_q(epc), .cause_q(cause)
  );

  assign flush_if    = flush[0];
  assign flush_id    = flush[1];
  assign flush_ex    = flush[2];
  assign flush_mem   = flush[3];
  assign redirect    = hit;
  assign redirect_pc = XLEN'(HANDLER);
endmodule

// File: rtl/pex_unit_chk.sv
module pex_unit_chk #(
  parameter int          XLEN          = 32,
  parameter logic [31:0] HANDLER       = 32'h8000_0180,
  parameter bit          HAS_MEM_FAULT = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            id_valid,
  input logic [XLEN-1:0] id_pc,
  input logic            id_undef,
  input logic            ex_valid,
  input logic [XLEN-1:0] ex_pc,
  input logic            ex_ovf,
  input logic            mem_valid,
  input logic [XLEN-1:0] mem_pc,
  input logic            mem_fault,
  input logic            flush_if,
  input logic            flush_id,
  input logic            flush_ex,
  input logic            flush_mem,
  input logic            redirect,
  input logic [XLEN-1:0] redirect_pc,
  input logic [XLEN-1:0] epc,
  input logic [1:0]      cause
);
  AST_RESET_CLEAN: assert property (@(posedge clk) $rose(rst_n) |-> (epc == '0 && cause == 2'd0)); // R1
  AST_ID_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && !flush_ex) |-> (flush_if && flush_id && !flush_mem)); // R2
  AST_EX_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && flush_ex && !flush_mem) |=> (cause == 2'd1)); // R3
  AST_FLUSH_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_mem |-> flush_ex) and (flush_ex |-> flush_id) and (flush_id |-> flush_if)); // R5
  AST_EPC_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && flush_mem) |=> (epc == $past(mem_pc) + XLEN'(4))); // R6
  AST_EPC_EX: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && flush_ex && !flush_mem) |=> (epc == $past(ex_pc) + XLEN'(4))); // R6
  AST_EPC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |=> ($stable(epc) && $stable(cause))); // R7
  AST_BUBBLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_valid && !ex_valid && !mem_valid) |-> !redirect); // R8
  AST_HANDLER_PC: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (redirect_pc == XLEN'(HANDLER))); // R9
  if (HAS_MEM_FAULT) begin : g_memchk
    AST_MEM_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_fault) |-> (flush_mem && redirect)); // R4
  end else begin : g_nomemchk
    AST_MEM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !flush_mem); // R10
  end
endmodule

bind pex_unit pex_unit_chk #(.XLEN(XLEN), .HANDLER(HANDLER), .HAS_MEM_FAULT(HAS_MEM_FAULT)) u_chk (.*);

// File: tb/test_pex_unit.sv
module test_pex_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        id_valid = 0, id_undef = 0, ex_valid = 0, ex_ovf = 0, mem_valid = 0, mem_fault = 0;
  logic [31:0] id_pc = 0, ex_pc = 0, mem_pc = 0;
  logic        flush_if, flush_id, flush_ex, flush_mem, redirect;
  logic [31:0] redirect_pc, epc;
  logic [1:0]  cause;
  logic        nf_if, nf_id, nf_ex, nf_mem, n_redir;
  logic [31:0] n_rpc, n_epc;
  logic [1:0]  n_cause;

  pex_unit i_pex_unit (
    .clk, .rst_n, .id_valid, .id_pc, .id_undef, .ex_valid, .ex_pc, .ex_ovf,
    .mem_valid, .mem_pc, .mem_fault, .flush_if, .flush_id, .flush_ex, .flush_mem,
    .redirect, .redirect_pc, .epc, .cause
  );

  pex_unit #(.HAS_MEM_FAULT(1'b0)) i_pex_unit_nomem (
    .clk, .rst_n, .id_valid, .id_pc, .id_undef, .ex_valid, .ex_pc, .ex_ovf,
    .mem_valid, .mem_pc, .mem_fault, .flush_if(nf_if), .flush_id(nf_id),
    .flush_ex(nf_ex), .flush_mem(nf_mem), .redirect(n_redir), .redirect_pc(n_rpc),
    .epc(n_epc), .cause(n_cause)
  );

  typedef struct {
    logic [3:0]  fl;
    logic        redir;
    logic [31:0] epc_a;
    logic [1:0]  cause_a;
    logic        n_redir;
    string       req;
  } item_t;

  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_epc = 0;
  logic [1:0]  m_cause = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic iv, input logic [31:0] ip, input logic iu,
                       input logic ev, input logic [31:0] ep, input logic eo,
                       input logic mv, input logic [31:0] mp, input logic mf,
                       input string req);
    item_t it;
    int st;
    @(negedge clk);
    id_valid = iv; id_pc = ip; id_undef = iu;
    ex_valid = ev; ex_pc = ep; ex_ovf = eo;
    mem_valid = mv; mem_pc = mp; mem_fault = mf;
    st = (mv && mf) ? 3 : (ev && eo) ? 2 : (iv && iu) ? 1 : 0;
    it.fl = (st == 0) ? 4'b0000 : (st == 1) ? 4'b0011 : (st == 2) ? 4'b0111 : 4'b1111;
    it.redir = (st != 0);
    if (st != 0) begin
      m_epc   = ((st == 3) ? mp : (st == 2) ? ep : ip) + 32'd4;
      m_cause = 2'(st - 1);
    end
    it.epc_a = m_epc;
    it.cause_a = m_cause;
    it.n_redir = (ev && eo) || (iv && iu);
    it.req = req;
    q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #3;
      if (q.size() > 0) begin
        it = q.pop_front();
        chk({flush_mem, flush_ex, flush_id, flush_if} == it.fl, {it.req, " flush"},
            32'({flush_mem, flush_ex, flush_id, flush_if}), 32'(it.fl));
        chk(redirect == it.redir, {it.req, " redirect"}, 32'(redirect), 32'(it.redir));
        if (it.redir)
          chk(redirect_pc == 32'h8000_0180, "R9 handler pc", redirect_pc, 32'h8000_0180);
        chk(n_redir == it.n_redir, {it.req, " R10 no-mem variant redirect"}, 32'(n_redir), 32'(it.n_redir));
        @(posedge clk);
        #1;
        chk(epc == it.epc_a, {it.req, " R6/R7 epc"}, epc, it.epc_a);
        chk(cause == it.cause_a, {it.req, " cause"}, 32'(cause), 32'(it.cause_a));
      end
    end
  end

  initial begin : watchdog
    #1000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1;
    chk(epc == 0, "R1 reset epc", epc, 0);
    chk(cause == 0, "R1 reset cause", 32'(cause), 0);
    chk(!redirect && !flush_if, "R1 reset idle", 32'(redirect), 0);
    @(negedge clk) rst_n = 1'b1;
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, "R7 idle");
    drive(1, 32'h1000, 1, 1, 32'h0ffc, 0, 1, 32'h0ff8, 0, "R2 decode undef");
    drive(1, 32'h1100, 0, 0, 0, 0, 0, 0, 0, "R7 quiet");
    drive(1, 32'h2004, 0, 1, 32'h2000, 1, 1, 32'h1ffc, 0, "R3 execute ovf");
    drive(1, 32'h3008, 0, 1, 32'h3004, 0, 1, 32'h3000, 1, "R4 mem fault");
    drive(1, 32'h4008, 1, 1, 32'h4004, 1, 1, 32'h4000, 1, "R5 all three");
    drive(1, 32'h5004, 1, 1, 32'h5000, 1, 0, 0, 0, "R5 decode+execute");
    drive(0, 32'h6008, 1, 0, 32'h6004, 1, 0, 32'h6000, 1, "R8 bubbles");
    drive(1, 32'h7004, 1, 0, 32'h7000, 1, 0, 0, 0, "R8 squashed execute");
    drive(0, 0, 0, 0, 0, 0, 1, 32'h8000, 1, "R4 R10 mem only");
    drive(0, 0, 0, 1, 32'hFFFF_FFFC, 1, 0, 0, 0, "R6 wrap");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 single-cycle redirect");
    wait (q.size() == 0);
    repeat (3) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule